// File: doc/BRIEF.md
# Statically Scheduled Broadcast Switch Port

This block is one port of a crossbar that joins a set of processors running in lock step. On every instruction step each processor places its result for that step on a shared bus, and every port sees all of them at once. The port holds a select table that was compiled before the run and is loaded through a configuration port. The table entry addressed by the current step number names the one processor whose result the port takes at that step. Nothing is arbitrated while the run is going. The received value is written into the port's input memory at the address equal to the step number. The attached processor reads that memory as part of its own operand address space.

Each table entry has an enable bit. A cleared enable bit, or a select code at or above the processor count, means that nothing arrives at that step, and the input memory keeps its old contents. In unit-delay mode the input memory is split into two halves. The half that receives writes follows a phase bit that the sequencer toggles every simulation cycle, in step with the data memory. The reader names the half it wants, so a delivered value is seen exactly one simulation cycle later. In rank-order mode only one half is in use, for both writes and reads.

The step stream (`step_vld_i` with `step_i` and `res_i`) runs in lock step with all the processors and cannot be held back, so it has no ready signal. Every step offered is taken on the edge at which it is presented. The read port works the same way: a request is always accepted, and the answer comes back with a valid flag on the next cycle. No back-pressure is possible on either side.

Top module: `sw_bcast_port`

## Requirements
- R1: After reset every table entry is disabled, `rd_vld_o` is 0, and every input-memory location in both halves reads as 0.
- R2: On an edge with `step_vld_i` high, step K, and table entry K enabled with select code P < NPROC, the input-memory location K in the write half takes bits [P*VW +: VW] of `res_i`.
- R3: A step whose table entry is disabled leaves every input-memory location unchanged.
- R4: In unit-delay mode (`mode_i` = 1), the write half is `phase_i` (0 = half A, 1 = half B), and the other half is not written.
- R5: In rank-order mode (`mode_i` = 0), writes go to half A whatever `phase_i` is, and reads return half A whatever `rd_half_i` is.
- R6: A read request on one edge gives `rd_vld_o` = 1 with the data of location {half, `rd_addr_i`} in the next cycle. With no request, `rd_vld_o` is 0 in the next cycle.
- R7: A read of a location on the same edge as a write to that location returns the old value. Reads issued on later edges return the new value.
- R8: Edges with `step_vld_i` low write nothing, whatever `res_i` and `step_i` carry.
- R9: An enabled entry whose select code is NPROC or above (codes 6 and 7 when NPROC = 6) receives nothing, and its location stays unchanged.
- R10: A configuration write (`cfg_we_i`) sets entry `cfg_addr_i` to {`cfg_en_i`, `cfg_sel_i`}. It leaves the input memory untouched, and the next step that uses the entry follows the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_vld_i | input | 1 | A step is presented this cycle |
| step_i | input | AW | Shared step counter value |
| res_i | input | NPROC*VW | Results of all processors for this step, processor p at [p*VW +: VW] |
| mode_i | input | 1 | 1 = unit-delay (split halves), 0 = rank-order |
| phase_i | input | 1 | Write half in unit-delay mode |
| cfg_we_i | input | 1 | Select-table write strobe |
| cfg_addr_i | input | AW | Select-table entry to write |
| cfg_en_i | input | 1 | Receive enable for the entry |
| cfg_sel_i | input | SEL_W | Processor select code for the entry |
| rd_req_i | input | 1 | Input-memory read request |
| rd_addr_i | input | AW | Input-memory read location |
| rd_half_i | input | 1 | Half to read in unit-delay mode |
| rd_vld_o | output | 1 | Read data valid |
| rd_data_o | output | VW | Read data |

## Verification
The hardest case to produce from the ports is a read and a write that hit the same location on the same edge. A sweep of steps almost never lines up with a read of the very location being written. To get there, a directed sequence drives one step and a read of its location together, checks that the old value comes back, and then reads the location again. A second problem is that the invalid select codes and rank-order mode change the memory only by writing nothing, which cannot be seen at the ports. Random tables therefore contain every code from 0 to 7, and each sweep ends with a full read-back of both halves, compared against a bench model of the memory.

// File: rtl/sw_port_pkg.sv
package sw_port_pkg;

  typedef enum logic {
    MODE_RANK = 1'b0,
    MODE_UNIT = 1'b1
  } sim_mode_e;

  // Half actually addressed: rank-order mode folds everything onto half A.
  function automatic logic eff_half(input logic unit_mode, input logic half);
    return unit_mode & half;
  endfunction

endpackage

// File: rtl/sw_sel_table.sv
module sw_sel_table #(
  parameter int DEPTH = 64,
  parameter int SEL_W = 3,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic             wr_en_bit_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic             rd_en_bit_o,
  output logic [SEL_W-1:0] rd_sel_o
);

  logic             en_q  [DEPTH];
  logic [SEL_W-1:0] sel_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        en_q[i]  <= 1'b0;
        sel_q[i] <= '0;
      end
    end else if (wr_i) begin
      en_q[wr_addr_i]  <= wr_en_bit_i;
      sel_q[wr_addr_i] <= wr_sel_i;
    end
  end

  // Table is read in the same cycle the step is presented.
  assign rd_en_bit_o = en_q[rd_addr_i];
  assign rd_sel_o    = sel_q[rd_addr_i];

endmodule

// File: rtl/sw_fwd_mux.sv
module sw_fwd_mux #(
  parameter int NPROC = 6,
  parameter int VW    = 2,
  localparam int SEL_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic [NPROC*VW-1:0] res_i,
  input  logic                en_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                hit_o,
  output logic [VW-1:0]       val_o
);

  logic [VW-1:0] lane [NPROC];

  for (genvar p = 0; p < NPROC; p++) begin : g_lane
    assign lane[p] = res_i[p*VW +: VW];
  end

  // One-hot match per lane; codes beyond the last lane match nothing.
  always_comb begin
    hit_o = 1'b0;
    val_o = '0;
    for (int p = 0; p < NPROC; p++) begin
      if (en_i && (sel_i == SEL_W'(p))) begin
        hit_o = 1'b1;
        val_o = lane[p];
      end
    end
  end

endmodule

// File: rtl/sw_in_mem.sv
module sw_in_mem #(
  parameter int VW = 2,
  parameter int AW = 6,
  localparam int MW = AW + 1,
  localparam int ENTRIES = 2 ** MW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [MW-1:0] waddr_i,
  input  logic [VW-1:0] wdata_i,
  input  logic          rd_req_i,
  input  logic [MW-1:0] raddr_i,
  output logic          rd_vld_o,
  output logic [VW-1:0] rd_data_o
);

  logic [VW-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // Registered read: samples the array before this edge's write lands.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld_o  <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_vld_o <= rd_req_i;
      if (rd_req_i) rd_data_o <= mem_q[raddr_i];
    end
  end

endmodule

// File: rtl/sw_bcast_port.sv
module sw_bcast_port
  import sw_port_pkg::*;
#(
  parameter int NPROC = 6,
  parameter int VW    = 2,
  parameter int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int SEL_W = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int MW    = AW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_vld_i,
  input  logic [AW-1:0]       step_i,
  input  logic [NPROC*VW-1:0] res_i,
  input  logic                mode_i,
  input  logic                phase_i,
  input  logic                cfg_we_i,
  input  logic [AW-1:0]       cfg_addr_i,
  input  logic                cfg_en_i,
  input  logic [SEL_W-1:0]    cfg_sel_i,
  input  logic                rd_req_i,
  input  logic [AW-1:0]       rd_addr_i,
  input  logic                rd_half_i,
  output logic                rd_vld_o,
  output logic [VW-1:0]       rd_data_o
);

  logic             tab_en;
  logic [SEL_W-1:0] tab_sel;
  logic             hit;
  logic [VW-1:0]    fwd_val;
  logic             wr_en;
  logic [MW-1:0]    wr_addr;
  logic [MW-1:0]    rd_addr;
  logic             unit_mode;

  assign unit_mode = (sim_mode_e'(mode_i) == MODE_UNIT);

  sw_sel_table #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_tab (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (cfg_we_i),
    .wr_addr_i   (cfg_addr_i),
    .wr_en_bit_i (cfg_en_i),
    .wr_sel_i    (cfg_sel_i),
    .rd_addr_i   (step_i),
    .rd_en_bit_o (tab_en),
    .rd_sel_o    (tab_sel)
  );

  sw_fwd_mux #(.NPROC(NPROC), .VW(VW)) u_mux (
    .res_i (res_i),
    .en_i  (tab_en),
    .sel_i (tab_sel),
    .hit_o (hit),
    .val_o (fwd_val)
  );

  assign wr_en   = step_vld_i & hit;
  assign wr_addr = {eff_half(unit_mode, phase_i), step_i};
  assign rd_addr = {eff_half(unit_mode, rd_half_i), rd_addr_i};

  sw_in_mem #(.VW(VW), .AW(AW)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (wr_en),
    .waddr_i   (wr_addr),
    .wdata_i   (fwd_val),
    .rd_req_i  (rd_req_i),
    .raddr_i   (rd_addr),
    .rd_vld_o  (rd_vld_o),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/sw_port_chk.sv
module sw_port_chk #(
  parameter int NPROC = 6,
  parameter int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int SEL_W = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int MW    = AW + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_vld_i,
  input logic [AW-1:0]    step_i,
  input logic             mode_i,
  input logic             phase_i,
  input logic             rd_req_i,
  input logic             rd_vld_o,
  input logic             tab_en,
  input logic [SEL_W-1:0] tab_sel,
  input logic             wr_en,
  input logic [MW-1:0]    wr_addr
);

  localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(NPROC);

  a_r6_rd_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> rd_vld_o);
  a_r6_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> !rd_vld_o);
  a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !step_vld_i |-> !wr_en);
  a_r3_r9_write_needs_valid_entry: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (tab_en && ({1'b0, tab_sel} < LIMIT)));
  a_r2_write_at_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr[AW-1:0] == step_i));
  a_r4_unit_half: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_i) |-> (wr_addr[AW] == phase_i));
  a_r5_rank_half: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mode_i) |-> (wr_addr[AW] == 1'b0));

endmodule

bind sw_bcast_port sw_port_chk #(.NPROC(NPROC), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_vld_i (step_vld_i),
  .step_i     (step_i),
  .mode_i     (mode_i),
  .phase_i    (phase_i),
  .rd_req_i   (rd_req_i),
  .rd_vld_o   (rd_vld_o),
  .tab_en     (tab_en),
  .tab_sel    (tab_sel),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr)
);

// File: tb/sim_sw_bcast_port.sv
`timescale 1ns/1ps
module sim_sw_bcast_port;

  localparam int NPROC = 6;
  localparam int VW    = 2;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int SEL_W = 3;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                step_vld;
  logic [AW-1:0]       step;
  logic [NPROC*VW-1:0] res;
  logic                mode;
  logic                phase;
  logic                cfg_we;
  logic [AW-1:0]       cfg_addr;
  logic                cfg_en;
  logic [SEL_W-1:0]    cfg_sel;
  logic                rd_req;
  logic [AW-1:0]       rd_addr;
  logic                rd_half;
  logic                rd_vld;
  logic [VW-1:0]       rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic             m_en  [DEPTH];
  logic [SEL_W-1:0] m_sel [DEPTH];
  logic [VW-1:0]    m_mem [2][DEPTH];

  always #4 clk = ~clk;

  sw_bcast_port #(.NPROC(NPROC), .VW(VW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .step_vld_i(step_vld), .step_i(step), .res_i(res),
    .mode_i(mode), .phase_i(phase), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_en_i(cfg_en), .cfg_sel_i(cfg_sel), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rd_half_i(rd_half), .rd_vld_o(rd_vld), .rd_data_o(rd_data)
  );

  function automatic logic eff(input logic m, input logic h);
    return m & h;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int a, input logic e, input int s);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_en = e; cfg_sel = SEL_W'(s);
    @(negedge clk);
    cfg_we = 1'b0;
    m_en[a] = e; m_sel[a] = SEL_W'(s);
  endtask

  // Model of one step edge (R2, R3, R4, R5, R9).
  function automatic void model_step(input int k, input logic m, input logic ph,
                                     input logic [NPROC*VW-1:0] r);
    if (m_en[k] && int'(m_sel[k]) < NPROC)
      m_mem[eff(m, ph)][k] = r[int'(m_sel[k])*VW +: VW];
  endfunction

  task automatic do_step(input int k, input logic m, input logic ph,
                         input logic [NPROC*VW-1:0] r);
    step_vld = 1'b1; step = AW'(k); mode = m; phase = ph; res = r;
    @(negedge clk);
    step_vld = 1'b0;
    model_step(k, m, ph, r);
  endtask

  task automatic rd_chk(input string req, input logic m, input logic h, input int a);
    mode = m; rd_req = 1'b1; rd_half = h; rd_addr = AW'(a);
    @(negedge clk);
    rd_req = 1'b0;
    chk({req, " rd_vld"}, 32'(rd_vld), 32'd1);
    chk(req, 32'(rd_data), 32'(m_mem[eff(m, h)][a]));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] old_v;
    logic [NPROC*VW-1:0] r;
    void'($urandom(32'd2024));
    rst_n = 1'b0; step_vld = 0; step = '0; res = '0; mode = 1; phase = 0;
    cfg_we = 0; cfg_addr = '0; cfg_en = 0; cfg_sel = '0;
    rd_req = 0; rd_addr = '0; rd_half = 0;
    for (int i = 0; i < DEPTH; i++) begin
      m_en[i] = 0; m_sel[i] = '0; m_mem[0][i] = '0; m_mem[1][i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rd_vld after reset", 32'(rd_vld), 32'd0);
    rd_chk("R1 half B loc 0", 1'b1, 1'b1, 0);
    rd_chk("R1 half A loc 63", 1'b1, 1'b0, 63);
    // R1/R3: steps with all entries disabled write nothing
    for (int k = 0; k < 4; k++) do_step(k, 1'b1, k[0], 12'hfff);
    for (int k = 0; k < 4; k++) rd_chk("R1 R3 disabled after reset", 1'b1, k[0], k);

    // R6: no request gives no valid
    @(negedge clk);
    chk("R6 rd_vld without request", 32'(rd_vld), 32'd0);

    // R2, R4: unit-delay write into half B
    load(5, 1'b1, 2);
    r = 12'h0;
    r[2*VW +: VW] = 2'd3;
    do_step(5, 1'b1, 1'b1, r);
    rd_chk("R2 delivered value", 1'b1, 1'b1, 5);
    rd_chk("R4 other half untouched", 1'b1, 1'b0, 5);
    chk("R2 expected literal", 32'(m_mem[1][5]), 32'd3);

    // R5: rank-order ignores phase and rd_half
    load(7, 1'b1, 4);
    r = 12'h0;
    r[4*VW +: VW] = 2'd2;
    do_step(7, 1'b0, 1'b1, r);
    rd_chk("R5 rank read with half=1", 1'b0, 1'b1, 7);
    chk("R5 rank literal", 32'(rd_data), 32'd2);
    rd_chk("R5 half B not written", 1'b1, 1'b1, 7);

    // R9: out-of-range select codes write nothing
    load(9, 1'b1, 6);
    load(10, 1'b1, 7);
    do_step(9, 1'b1, 1'b0, 12'hfff);
    do_step(10, 1'b1, 1'b0, 12'hfff);
    rd_chk("R9 code 6", 1'b1, 1'b0, 9);
    rd_chk("R9 code 7", 1'b1, 1'b0, 10);

    // R8: step_vld low with busy inputs
    load(11, 1'b1, 0);
    step = AW'(11); res = 12'hfff; mode = 1; phase = 0;
    repeat (3) @(negedge clk);
    rd_chk("R8 idle edges", 1'b1, 1'b0, 11);

    // R7: read and write on the same edge
    r = 12'h0;
    r[0 +: VW] = 2'd1;
    old_v = m_mem[0][11];
    step_vld = 1; step = AW'(11); mode = 1; phase = 0; res = r;
    rd_req = 1; rd_addr = AW'(11); rd_half = 0;
    @(negedge clk);
    step_vld = 0; rd_req = 0;
    model_step(11, 1'b1, 1'b0, r);
    chk("R7 same-edge old value", 32'(rd_data), 32'(old_v));
    rd_chk("R7 later read new value", 1'b1, 1'b0, 11);

    // R10: reload an entry; memory untouched, next step follows it
    load(5, 1'b1, 1);
    rd_chk("R10 reload leaves memory", 1'b1, 1'b1, 5);
    r = 12'h0;
    r[1*VW +: VW] = 2'd1;
    do_step(5, 1'b1, 1'b1, r);
    rd_chk("R10 new select used", 1'b1, 1'b1, 5);
    load(5, 1'b0, 1);
    do_step(5, 1'b1, 1'b1, 12'hfff);
    rd_chk("R10 R3 disabled by reload", 1'b1, 1'b1, 5);

    // Random rounds: full tables, sweeps, full read-back (R2 R3 R4 R5 R8 R9)
    for (int rnd = 0; rnd < 6; rnd++) begin
      for (int a = 0; a < DEPTH; a++)
        load(a, ($urandom % 4) != 0, int'($urandom % 8));
      for (int k = 0; k < DEPTH; k++) begin
        if (($urandom % 8) != 0)
          do_step(k, rnd[0], rnd[1] ^ k[0], 12'($urandom));
        else begin
          step = AW'(k); res = 12'($urandom);
          @(negedge clk);
        end
      end
      for (int a = 0; a < DEPTH; a++) begin
        rd_chk("R2 R4 random half A", 1'b1, 1'b0, a);
        rd_chk("R2 R4 random half B", 1'b1, 1'b1, a);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule